// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a memory-mapped general purpose I/O controller for up to 32 pins. Software configures it through a 32-bit register bus. Each pin has the following controls: an input enable, an output enable, an output data latch, an output inversion mask and a pull-up enable. Drive-strength and alternate-function selection words are also held, but only as storage. The external world reaches each pin through two signals. One says whether something outside drives the pin, and the other gives the level it drives. Both signals pass through a two-stage synchronizer before they are used.

Each pin's level is resolved in a fixed priority: an external driver first, then the pin's own output, then the pull-up. The resolved level is gated by the input enable and kept in a read-only sample register. Four sticky pending sources watch that sample for each pin: level high, level low, rising edge and falling edge. Each pending bit is cleared by writing a one to it, and each has its own enable mask. Every pin has its own interrupt line. A pin whose output is enabled while an external driver is also present raises a per-pin contention flag.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A synchronous reset clears every register, including the configuration, the enables, the pending bits and the stored sample. Directly after reset, reads of the configuration and sample words return 0, and pin_oe, pin_out and pin_irq are 0.
- R2: For each pin, pin_oe equals its output-enable bit and pin_out equals output-enable AND (port bit XOR invert bit).
- R3: A pin's resolved level is ext_level when ext_drive is 1. Otherwise it is the internal output value when output is enabled. Otherwise it is the pull-up bit.
- R4: The sample register (word offset 0x00, read-only) holds the resolved level AND the input-enable bit, one bit per pin at the pin's index.
- R5: short_flag for a pin is 1 exactly when its output is enabled and the synchronized ext_drive is 1.
- R6: The high pending bit (0x2C) sets while the sample is 1, and the low pending bit (0x34) sets while it is 0. Both hold until cleared, so directly after reset with inputs disabled the low pending word reads all ones.
- R7: The rise pending bit (0x1C) sets when the new sample is 1 and the stored previous sample is 0. The fall pending bit (0x24) sets on the opposite change. Both are sticky.
- R8: A write to a pending word clears the bits where the data is 1 and leaves the other bits unchanged. A set condition in the same cycle wins over the clear.
- R9: pin_irq for a pin is the OR of rise, fall, high and low pending each ANDed with its enable (rise 0x18, fall 0x20, high 0x28, low 0x30).
- R10: An access with byte address bits [1:0] not zero, or an address at or above 0x44, reads as 0, changes no register, and gives bus_err = 1 with the read data. A mapped access gives bus_err = 0.
- R11: ext_drive and ext_level pass through two flip-flops. A rising ext_level seen with the rise pending source enabled raises pin_irq at the third rising clock edge after the change, and not before.
- R12: The drive-strength (0x14), alternate-enable (0x38) and alternate-select (0x3C) words read back what was written and have no effect on pin_out. Read data appears at the clock edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW (8) | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Access error, registered with the read data |
| ext_drive | input | N (32) | External source drives the pin |
| ext_level | input | N (32) | Level driven by the external source |
| pin_oe | output | N (32) | Output enable per pin |
| pin_out | output | N (32) | Driven output level per pin |
| short_flag | output | N (32) | Output enabled while an external driver is present |
| pin_irq | output | N (32) | Interrupt line per pin |

## Verification
Random mixes of external drive, output enable, port, inversion, pull-up and input enable are held steady. The bench then clears all pending words and compares the sample, the high and low pending words and each interrupt line against a bench-computed resolution. This separates the three priority levels from each other and from the input-enable gate. Directed sequences toggle the pull-up on input-enabled pins that nothing else drives. These check that edges set only rise or fall, that set-versus-clear collisions keep the bit, and that zeros in a clear word keep other bits. A single synchronized edge measures the two-stage latency to the interrupt line. Misaligned and out-of-range accesses show that no register is disturbed.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int DW = 32;

    typedef enum logic [4:0] {
        RG_SAMPLE   = 5'd0,
        RG_IN_EN    = 5'd1,
        RG_OUT_EN   = 5'd2,
        RG_PORT     = 5'd3,
        RG_PULL     = 5'd4,
        RG_DRIVE    = 5'd5,
        RG_RISE_EN  = 5'd6,
        RG_RISE_PND = 5'd7,
        RG_FALL_EN  = 5'd8,
        RG_FALL_PND = 5'd9,
        RG_HIGH_EN  = 5'd10,
        RG_HIGH_PND = 5'd11,
        RG_LOW_EN   = 5'd12,
        RG_LOW_PND  = 5'd13,
        RG_ALT_EN   = 5'd14,
        RG_ALT_SEL  = 5'd15,
        RG_INVERT   = 5'd16
    } reg_idx_e;

    localparam int NUM_REGS = 17;

    typedef struct packed {
        logic [DW-1:0] in_en;
        logic [DW-1:0] out_en;
        logic [DW-1:0] port;
        logic [DW-1:0] pull;
        logic [DW-1:0] drive;
        logic [DW-1:0] rise_en;
        logic [DW-1:0] fall_en;
        logic [DW-1:0] high_en;
        logic [DW-1:0] low_en;
        logic [DW-1:0] alt_en;
        logic [DW-1:0] alt_sel;
        logic [DW-1:0] invert;
    } cfg_t;

    typedef struct packed {
        logic [DW-1:0] rise;
        logic [DW-1:0] fall;
        logic [DW-1:0] high;
        logic [DW-1:0] low;
    } pend_t;

    // Word aligned and inside the map
    function automatic logic word_mapped(input logic [DW-1:0] byte_addr);
        return (byte_addr[1:0] == 2'b00) && (byte_addr < DW'(NUM_REGS * 4));
    endfunction

    // Level resolution: outside driver, then own driver, then pull-up
    function automatic logic resolve_level(input logic ext_on, input logic ext_val,
                                           input logic oe, input logic own_val,
                                           input logic pull_on);
        if (ext_on)
            return ext_val;
        else if (oe)
            return own_val;
        else
            return pull_on;
    endfunction

    function automatic logic [DW-1:0] pin_mask(input int n);
        logic [DW-1:0] m;
        m = '0;
        for (int k = 0; k < DW; k++)
            if (k < n) m[k] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++)
                stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++)
                stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int AW = 8,
    parameter int N  = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  pend_t         pend,
    input  logic [DW-1:0] sample,
    output cfg_t          cfg,
    output pend_t         clr,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_err
);

    localparam logic [DW-1:0] PMASK = pin_mask(N);

    logic [DW-1:0] addr_ext;
    logic          mapped;
    reg_idx_e      idx;
    logic          wr_ok;
    logic          rd_ok;
    logic [DW-1:0] wdat;
    logic [DW-1:0] rd_mux;
    cfg_t          cfg_q;

    assign addr_ext = DW'(req_addr);
    assign mapped   = word_mapped(addr_ext);
    assign idx      = reg_idx_e'(addr_ext[6:2]);
    assign wr_ok    = req_valid && req_write && mapped;
    assign rd_ok    = req_valid && !req_write && mapped;
    assign wdat     = req_wdata & PMASK;

    // Write-one-to-clear strobes towards the pending logic
    always_comb begin
        clr = '0;
        if (wr_ok) begin
            case (idx)
                RG_RISE_PND: clr.rise = wdat;
                RG_FALL_PND: clr.fall = wdat;
                RG_HIGH_PND: clr.high = wdat;
                RG_LOW_PND:  clr.low  = wdat;
                default:     clr      = '0;
            endcase
        end
    end

    always_comb begin
        case (idx)
            RG_SAMPLE:   rd_mux = sample;
            RG_IN_EN:    rd_mux = cfg_q.in_en;
            RG_OUT_EN:   rd_mux = cfg_q.out_en;
            RG_PORT:     rd_mux = cfg_q.port;
            RG_PULL:     rd_mux = cfg_q.pull;
            RG_DRIVE:    rd_mux = cfg_q.drive;
            RG_RISE_EN:  rd_mux = cfg_q.rise_en;
            RG_RISE_PND: rd_mux = pend.rise;
            RG_FALL_EN:  rd_mux = cfg_q.fall_en;
            RG_FALL_PND: rd_mux = pend.fall;
            RG_HIGH_EN:  rd_mux = cfg_q.high_en;
            RG_HIGH_PND: rd_mux = pend.high;
            RG_LOW_EN:   rd_mux = cfg_q.low_en;
            RG_LOW_PND:  rd_mux = pend.low;
            RG_ALT_EN:   rd_mux = cfg_q.alt_en;
            RG_ALT_SEL:  rd_mux = cfg_q.alt_sel;
            RG_INVERT:   rd_mux = cfg_q.invert;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            rsp_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err   <= req_valid && !mapped;
            rsp_rdata <= rd_ok ? rd_mux : '0;
            if (wr_ok) begin
                case (idx)
                    RG_IN_EN:   cfg_q.in_en   <= wdat;
                    RG_OUT_EN:  cfg_q.out_en  <= wdat;
                    RG_PORT:    cfg_q.port    <= wdat;
                    RG_PULL:    cfg_q.pull    <= wdat;
                    RG_DRIVE:   cfg_q.drive   <= wdat;
                    RG_RISE_EN: cfg_q.rise_en <= wdat;
                    RG_FALL_EN: cfg_q.fall_en <= wdat;
                    RG_HIGH_EN: cfg_q.high_en <= wdat;
                    RG_LOW_EN:  cfg_q.low_en  <= wdat;
                    RG_ALT_EN:  cfg_q.alt_en  <= wdat;
                    RG_ALT_SEL: cfg_q.alt_sel <= wdat;
                    RG_INVERT:  cfg_q.invert  <= wdat;
                    default:    cfg_q         <= cfg_q;
                endcase
            end
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core
    import gpio_irq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  ext_drv,
    input  logic [N-1:0]  ext_lvl,
    input  cfg_t          cfg,
    input  pend_t         clr,
    output pend_t         pend,
    output logic [DW-1:0] sample,
    output logic [N-1:0]  pin_oe,
    output logic [N-1:0]  pin_out,
    output logic [N-1:0]  short_flag,
    output logic [N-1:0]  pin_irq
);

    localparam logic [DW-1:0] PMASK = pin_mask(N);

    logic [DW-1:0] own_lvl;
    logic [DW-1:0] lvl;
    logic [DW-1:0] samp;
    logic [DW-1:0] irq_all;
    pend_t         set;
    pend_t         pend_q;
    logic [DW-1:0] sample_q;
    logic          unused_cfg;

    assign own_lvl = cfg.out_en & (cfg.port ^ cfg.invert);

    for (genvar i = 0; i < DW; i++) begin : g_pin
        if (i < N) begin : g_live
            assign lvl[i]  = resolve_level(ext_drv[i], ext_lvl[i], cfg.out_en[i],
                                           own_lvl[i], cfg.pull[i]);
            assign samp[i] = lvl[i] & cfg.in_en[i];
        end else begin : g_tie
            assign lvl[i]  = 1'b0;
            assign samp[i] = 1'b0;
        end
    end

    always_comb begin
        set.high = samp;
        set.low  = ~samp & PMASK;
        set.rise = samp & ~sample_q;
        set.fall = ~samp & sample_q;
    end

    // Set wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            sample_q <= '0;
        end else begin
            pend_q.rise <= (pend_q.rise & ~clr.rise) | set.rise;
            pend_q.fall <= (pend_q.fall & ~clr.fall) | set.fall;
            pend_q.high <= (pend_q.high & ~clr.high) | set.high;
            pend_q.low  <= (pend_q.low  & ~clr.low ) | set.low;
            sample_q    <= samp;
        end
    end

    assign irq_all = (pend_q.rise & cfg.rise_en) | (pend_q.fall & cfg.fall_en) |
                     (pend_q.high & cfg.high_en) | (pend_q.low  & cfg.low_en);

    assign pend       = pend_q;
    assign sample     = sample_q;
    assign pin_oe     = cfg.out_en[N-1:0];
    assign pin_out    = own_lvl[N-1:0];
    assign short_flag = cfg.out_en[N-1:0] & ext_drv;
    assign pin_irq    = irq_all[N-1:0];
    assign unused_cfg = ^{cfg.drive, cfg.alt_en, cfg.alt_sel, lvl, own_lvl, irq_all};

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int AW      = 8,
    parameter int N       = 32,
    parameter int SYNC_ST = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    output logic [31:0]   rsp_rdata,
    output logic          bus_err,
    input  logic [N-1:0]  ext_drive,
    input  logic [N-1:0]  ext_level,
    output logic [N-1:0]  pin_oe,
    output logic [N-1:0]  pin_out,
    output logic [N-1:0]  short_flag,
    output logic [N-1:0]  pin_irq
);

    logic [2*N-1:0] ext_sync;
    cfg_t           cfg_q;
    pend_t          pend_q;
    pend_t          pend_clr;
    logic [DW-1:0]  val_q;

    gpio_irq_sync #(.W(2*N), .STAGES(SYNC_ST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ext_drive, ext_level}),
        .q   (ext_sync)
    );

    gpio_irq_regs #(.AW(AW), .N(N)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .pend      (pend_q),
        .sample    (val_q),
        .cfg       (cfg_q),
        .clr       (pend_clr),
        .rsp_rdata (rsp_rdata),
        .bus_err   (bus_err)
    );

    gpio_irq_core #(.N(N)) u_core (
        .clk        (clk),
        .rst        (rst),
        .ext_drv    (ext_sync[2*N-1:N]),
        .ext_lvl    (ext_sync[N-1:0]),
        .cfg        (cfg_q),
        .clr        (pend_clr),
        .pend       (pend_q),
        .sample     (val_q),
        .pin_oe     (pin_oe),
        .pin_out    (pin_out),
        .short_flag (short_flag),
        .pin_irq    (pin_irq)
    );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int N = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          bus_err,
    input logic [N-1:0]  pin_oe,
    input logic [N-1:0]  pin_out,
    input logic [N-1:0]  short_flag,
    input logic [N-1:0]  pin_irq,
    input cfg_t          cfg,
    input pend_t         pend,
    input pend_t         clr,
    input logic [DW-1:0] sample
);

    // R2: a pin that is not enabled as output never drives high
    p_out_gated_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((pin_out & ~pin_oe) == '0));

    // R5: contention only on output-enabled pins
    p_short_needs_oe_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((short_flag & ~pin_oe) == '0));

    // R6 / R8: pending bits only fall when a clear strobe hits them
    p_high_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(pend.high) & ~$past(clr.high)) & ~pend.high) == '0));

    p_low_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(pend.low) & ~$past(clr.low)) & ~pend.low) == '0));

    // R7: a rising sample is always accompanied by its rise pending bit
    p_rise_follows_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((sample & ~$past(sample) & ~pend.rise) == '0));

    // R9: an interrupt line needs at least one enabled source
    p_irq_enabled_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((pin_irq & ~(cfg.rise_en[N-1:0] | cfg.fall_en[N-1:0] |
                               cfg.high_en[N-1:0] | cfg.low_en[N-1:0])) == '0));

    // R10: an error response only follows an access
    p_err_after_req_r10: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(req_valid));

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .bus_err    (bus_err),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .short_flag (short_flag),
    .pin_irq    (pin_irq),
    .cfg        (cfg_q),
    .pend       (pend_q),
    .clr        (pend_clr),
    .sample     (val_q)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;

    localparam int AW = 8;
    localparam int N  = 32;

    localparam logic [7:0] A_SAMPLE = 8'h00, A_IN_EN = 8'h04, A_OUT_EN = 8'h08,
                           A_PORT = 8'h0C, A_PULL = 8'h10, A_DRIVE = 8'h14,
                           A_RISE_EN = 8'h18, A_RISE_P = 8'h1C, A_FALL_EN = 8'h20,
                           A_FALL_P = 8'h24, A_HIGH_EN = 8'h28, A_HIGH_P = 8'h2C,
                           A_LOW_EN = 8'h30, A_LOW_P = 8'h34, A_ALT_EN = 8'h38,
                           A_ALT_SEL = 8'h3C, A_INVERT = 8'h40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rsp_rdata;
    logic          bus_err;
    logic [N-1:0]  ext_drive = '0;
    logic [N-1:0]  ext_level = '0;
    logic [N-1:0]  pin_oe, pin_out, short_flag, pin_irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic last_err;

    always #2 clk = ~clk;

    gpio_irq_ctrl #(.AW(AW), .N(N)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .bus_err(bus_err), .ext_drive(ext_drive), .ext_level(ext_level),
        .pin_oe(pin_oe), .pin_out(pin_out), .short_flag(short_flag), .pin_irq(pin_irq)
    );

    function automatic logic [31:0] f_level(input logic [31:0] drv, input logic [31:0] lvl,
                                            input logic [31:0] oe, input logic [31:0] prt,
                                            input logic [31:0] inv, input logic [31:0] pu);
        return (drv & lvl) | (~drv & oe & (prt ^ inv)) | (~drv & ~oe & pu);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        last_err = bus_err;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        d = rsp_rdata;
        last_err = bus_err;
        req_valid = 1'b0;
    endtask

    task automatic clear_pending();
        bus_wr(A_RISE_P, 32'hFFFF_FFFF);
        bus_wr(A_FALL_P, 32'hFFFF_FFFF);
        bus_wr(A_HIGH_P, 32'hFFFF_FFFF);
        bus_wr(A_LOW_P,  32'hFFFF_FFFF);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_rd(A_PORT, rd);    chk("R1 port after reset", rd, 32'h0);
        bus_rd(A_OUT_EN, rd);  chk("R1 out_en after reset", rd, 32'h0);
        bus_rd(A_IN_EN, rd);   chk("R1 in_en after reset", rd, 32'h0);
        bus_rd(A_SAMPLE, rd);  chk("R1 sample after reset", rd, 32'h0);
        bus_rd(A_RISE_P, rd);  chk("R1 rise pending after reset", rd, 32'h0);
        bus_rd(A_HIGH_P, rd);  chk("R1 high pending after reset", rd, 32'h0);
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 pin_irq", pin_irq, 32'h0);
        // R6 low pending sets from a zero sample
        bus_rd(A_LOW_P, rd);   chk("R6 low pending after reset", rd, 32'hFFFF_FFFF);

        // R2 output path
        bus_wr(A_OUT_EN, 32'hFFFF_0000);
        bus_wr(A_PORT,   32'h0F0F_0F0F);
        bus_wr(A_INVERT, 32'h00FF_00FF);
        @(negedge clk);
        chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        chk("R2 pin_out", pin_out, 32'hFFFF_0000 & (32'h0F0F_0F0F ^ 32'h00FF_00FF));

        // R12 storage-only words
        bus_wr(A_DRIVE,   32'hA5A5_1234);
        bus_wr(A_ALT_EN,  32'h5555_AAAA);
        bus_wr(A_ALT_SEL, 32'hDEAD_BEEF);
        bus_rd(A_DRIVE, rd);   chk("R12 drive readback", rd, 32'hA5A5_1234);
        bus_rd(A_ALT_EN, rd);  chk("R12 alt_en readback", rd, 32'h5555_AAAA);
        bus_rd(A_ALT_SEL, rd); chk("R12 alt_sel readback", rd, 32'hDEAD_BEEF);
        chk("R12 pin_out unchanged", pin_out, 32'hFFFF_0000 & (32'h0F0F_0F0F ^ 32'h00FF_00FF));

        // R10 bad accesses
        bus_rd(8'h44, rd);     chk("R10 unmapped read data", rd, 32'h0);
        chk("R10 unmapped read err", {31'b0, last_err}, 32'h1);
        bus_wr(8'h0D, 32'hFFFF_FFFF);
        chk("R10 misaligned write err", {31'b0, last_err}, 32'h1);
        bus_wr(8'h80, 32'hFFFF_FFFF);
        chk("R10 high write err", {31'b0, last_err}, 32'h1);
        bus_rd(A_PORT, rd);    chk("R10 port untouched", rd, 32'h0F0F_0F0F);
        chk("R10 mapped access no err", {31'b0, last_err}, 32'h0);
        bus_rd(8'h42, rd);     chk("R10 misaligned read data", rd, 32'h0);

        // R6 R7 R8 edges and clear rules on pins 0 and 1
        bus_wr(A_OUT_EN, 32'h0);
        bus_wr(A_INVERT, 32'h0);
        bus_wr(A_PULL,   32'h0);
        bus_wr(A_IN_EN,  32'h3);
        repeat (3) @(negedge clk);
        clear_pending();
        bus_wr(A_PULL, 32'h3);
        bus_rd(A_RISE_P, rd);  chk("R7 rise pending set", rd, 32'h3);
        bus_rd(A_FALL_P, rd);  chk("R7 no fall on rise", rd, 32'h0);
        bus_wr(A_RISE_P, 32'h1);
        bus_rd(A_RISE_P, rd);  chk("R8 clear keeps zero-data bits", rd, 32'h2);
        bus_wr(A_HIGH_P, 32'h3);
        bus_rd(A_HIGH_P, rd);  chk("R8 set wins over clear", rd, 32'h3);
        bus_wr(A_PULL, 32'h0);
        repeat (2) @(negedge clk);
        bus_rd(A_FALL_P, rd);  chk("R7 fall pending set", rd, 32'h3);
        bus_rd(A_RISE_P, rd);  chk("R7 rise stays sticky", rd, 32'h2);
        bus_rd(A_HIGH_P, rd);  chk("R6 high stays after low", rd, 32'h3);
        bus_rd(A_SAMPLE, rd);  chk("R4 sample low", rd, 32'h0);

        // R11 synchronizer latency on pin 0
        bus_wr(A_IN_EN, 32'h1);
        bus_wr(A_RISE_EN, 32'h1);
        @(negedge clk);
        ext_drive = 32'h1; ext_level = 32'h0;
        repeat (4) @(negedge clk);
        bus_wr(A_RISE_P, 32'hFFFF_FFFF);
        chk("R11 irq idle", {31'b0, pin_irq[0]}, 32'h0);
        ext_level = 32'h1;
        @(negedge clk); chk("R11 irq after 1 edge", {31'b0, pin_irq[0]}, 32'h0);
        @(negedge clk); chk("R11 irq after 2 edges", {31'b0, pin_irq[0]}, 32'h0);
        @(negedge clk); chk("R11 irq after 3 edges", {31'b0, pin_irq[0]}, 32'h1);
        bus_wr(A_RISE_EN, 32'h0);

        // Random steady-state patterns: R3 R4 R5 R6 R7 R9
        for (int it = 0; it < 40; it++) begin
            logic [31:0] ie, oe, pt, iv, pu, he, le, dr, lv, exp_s;
            ie = $urandom; oe = $urandom; pt = $urandom; iv = $urandom;
            pu = $urandom; he = $urandom; le = $urandom; dr = $urandom; lv = $urandom;
            if (it == 0) begin dr = 32'h0; oe = 32'h0; ie = 32'hFFFF_FFFF; end
            if (it == 1) begin dr = 32'hFFFF_FFFF; ie = 32'hFFFF_FFFF; end
            bus_wr(A_IN_EN, ie);  bus_wr(A_OUT_EN, oe); bus_wr(A_PORT, pt);
            bus_wr(A_INVERT, iv); bus_wr(A_PULL, pu);
            bus_wr(A_HIGH_EN, he); bus_wr(A_LOW_EN, le);
            bus_wr(A_FALL_EN, 32'h0);
            ext_drive = dr; ext_level = lv;
            repeat (5) @(negedge clk);
            clear_pending();
            exp_s = f_level(dr, lv, oe, pt, iv, pu) & ie;
            bus_rd(A_SAMPLE, rd);  chk("R3/R4 sample", rd, exp_s);
            bus_rd(A_HIGH_P, rd);  chk("R6 high pending", rd, exp_s);
            bus_rd(A_LOW_P, rd);   chk("R6 low pending", rd, ~exp_s);
            bus_rd(A_RISE_P, rd);  chk("R7 no rise when steady", rd, 32'h0);
            chk("R9 irq lines", pin_irq, (exp_s & he) | (~exp_s & le));
            chk("R5 short flag", short_flag, oe & dr);
            chk("R2 pin_out random", pin_out, oe & (pt ^ iv));
        end

        summary();
        $finish;
    end

endmodule